// File: doc/BRIEF.md
# External Bus Master with Dynamic Port Sizing

This block sits between an on-chip request port and a shared external bus with a 24-bit address and a 16-bit data path. It carries out each internal transfer as one or more external bus cycles. A sideband input gives the width of the addressed device's port: 8 or 16 bits. A 16-bit transfer to an 8-bit device becomes two byte cycles. A byte transfer to a 16-bit device is steered onto one data lane by address bit 0. An 8-bit device always sits on the upper lane. Each cycle holds its strobe, address and data until the device acknowledges it. A one-cycle response then returns any read data.

The block also shares the bus with another master through three wires. The other master raises a request. This block answers with a grant, but only while it is between cycles. The other master then holds a grant-acknowledge line for as long as it owns the bus. During that time this block drives nothing and stalls its own requests. A request may be marked locked. From the start of that request until the next request completes, a read-modify-write indicator stays high and no grant is given. The locked pair therefore cannot be split by the other master.

Top module: `ebus_master`

## Requirements
- R1: While reset is held, bus_strobe, bus_addr_oe, bus_dout_oe, arb_grant, bus_rmw and rsp_valid are 0. After release with no arbitration activity, req_ready is 1.
- R2: A word request (req_word=1) to a 16-bit device (req_port8=0) runs one bus cycle. The address has bit 0 cleared and both lane enables are 1. bus_dout carries the whole write word. The read result is bus_din unchanged.
- R3: A word request to an 8-bit device (req_port8=1) runs two bus cycles, both with only bus_lane_hi enabled. The first uses the even address and carries write bits [15:8] on bus_dout[15:8]. The second uses the even address plus one and carries write bits [7:0] on bus_dout[15:8]. A read returns the first cycle's bus_din[15:8] in rsp_rdata[15:8] and the second cycle's in rsp_rdata[7:0].
- R4: A byte request (req_word=0) to a 16-bit device uses the address unchanged. Address bit 0 = 0 selects the upper lane (bus_lane_hi, bus_dout[15:8], bus_din[15:8]). Address bit 0 = 1 selects the lower lane (bus_lane_lo, bits [7:0]). The write byte is req_wdata[7:0]. The read byte is returned in rsp_rdata[7:0] with rsp_rdata[15:8] = 0.
- R5: A byte request to an 8-bit device uses the address unchanged and only the upper lane, whatever the value of address bit 0.
- R6: For a word request, bit 0 of req_addr is ignored: the cycle addresses are those of the even address.
- R7: A bus cycle keeps bus_strobe, bus_addr and bus_dout stable until bus_ack is sampled high. bus_ack while no cycle is running has no effect.
- R8: rsp_valid pulses high for exactly one cycle, the cycle after the edge that acknowledges the last bus cycle of a request. For a read, rsp_rdata holds the assembled data.
- R9: With no locked pair pending, arb_grant rises one cycle after arb_req is seen high while no bus cycle is running. It is never high during a bus cycle. While arb_grant or arb_gack is high, req_ready is 0, and bus_strobe, bus_addr_oe and bus_dout_oe are 0.
- R10: arb_grant falls one cycle after arb_req drops. Requests are accepted again once both arb_grant and arb_gack are low.
- R11: A request with req_lock=1 sets bus_rmw when it is accepted. bus_rmw stays high until the following unlocked request completes. While it is high, arb_grant stays 0 and requests are still accepted even if arb_req is high.
- R12: bus_dout_oe and bus_write are high only during the bus cycles of a write request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Internal request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit transfer, 0 = byte |
| req_lock | input | 1 | First half of a locked read-modify-write pair |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data (a byte uses bits [7:0]) |
| req_port8 | input | 1 | Sideband: the target device has an 8-bit port |
| rsp_valid | output | 1 | Request completed (one-cycle pulse) |
| rsp_rdata | output | 16 | Read data |
| bus_addr | output | 24 | External address |
| bus_addr_oe | output | 1 | Address drive enable |
| bus_strobe | output | 1 | Bus cycle in progress |
| bus_write | output | 1 | Cycle direction is write |
| bus_lane_hi | output | 1 | Upper data lane [15:8] active |
| bus_lane_lo | output | 1 | Lower data lane [7:0] active |
| bus_dout | output | 16 | Write data toward the bus |
| bus_dout_oe | output | 1 | Data drive enable |
| bus_din | input | 16 | Read data from the bus |
| bus_ack | input | 1 | Device completes the current cycle |
| bus_rmw | output | 1 | Locked read-modify-write sequence in progress |
| arb_req | input | 1 | Other master requests the bus |
| arb_grant | output | 1 | Bus granted to the other master |
| arb_gack | input | 1 | Other master owns the bus |

## Verification
The bench targets the split word transfer to an 8-bit device. A design with the wrong byte order or a missing second cycle returns swapped or half-filled read data and puts the wrong byte at the odd address. Byte lane steering is tested at both values of address bit 0, and a word request is given an odd address: a design that drops the bit-0 rule drives the wrong lane enable or an odd address. Stretched cycles with bus_ack held low expose a sequencer that moves on or changes the address early. The arbitration sequences raise arb_req during a cycle and between the two halves of a locked pair. A design that grants mid-cycle, lets the lock drop early, or keeps driving while the other master holds acknowledge shows a grant, strobe or ready where none may be.

// File: rtl/ebm_pkg.sv
package ebm_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_BEAT0 = 2'd1,
        PH_BEAT1 = 2'd2
    } ebm_phase_e;

endpackage

// File: rtl/ebm_lanes.sv
module ebm_lanes #(
    parameter int DW = 16
) (
    input  logic          word,
    input  logic          port8,
    input  logic          addr0,
    input  logic          second,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] din,
    input  logic [DW-1:0] rdata_q,
    output logic          lane_hi,
    output logic          lane_lo,
    output logic [DW-1:0] dout,
    output logic [DW-1:0] rdata_nx
);
    localparam int BW = DW / 2;

    always_comb begin
        lane_hi  = 1'b0;
        lane_lo  = 1'b0;
        dout     = '0;
        rdata_nx = rdata_q;
        if (word && !port8) begin
            lane_hi  = 1'b1;
            lane_lo  = 1'b1;
            dout     = wdata;
            rdata_nx = din;
        end else if (word) begin
            lane_hi = 1'b1;
            if (second) begin
                dout     = {wdata[BW-1:0], {BW{1'b0}}};
                rdata_nx = {rdata_q[DW-1:BW], din[DW-1:BW]};
            end else begin
                dout     = {wdata[DW-1:BW], {BW{1'b0}}};
                rdata_nx = {din[DW-1:BW], rdata_q[BW-1:0]};
            end
        end else if (!port8 && addr0) begin
            lane_lo  = 1'b1;
            dout     = {{BW{1'b0}}, wdata[BW-1:0]};
            rdata_nx = {{BW{1'b0}}, din[BW-1:0]};
        end else begin
            lane_hi  = 1'b1;
            dout     = {wdata[BW-1:0], {BW{1'b0}}};
            rdata_nx = {{BW{1'b0}}, din[DW-1:BW]};
        end
    end
endmodule

// File: rtl/ebm_arbiter.sv
module ebm_arbiter (
    input  logic clk,
    input  logic rst_n,
    input  logic arb_req,
    input  logic arb_gack,
    input  logic idle,
    input  logic lock,
    output logic grant
);
    logic grant_d, grant_q;

    always_comb begin
        grant_d = grant_q;
        if (grant_q && !arb_req)
            grant_d = 1'b0;
        else if (!grant_q && arb_req && idle && !lock && !arb_gack)
            grant_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) grant_q <= 1'b0;
        else        grant_q <= grant_d;
    end

    assign grant = grant_q;

    // R10: grant is withdrawn one cycle after the request drops
    a_r10_grant_drop: assert property (@(posedge clk) disable iff (!rst_n)
        grant_q && !arb_req |=> !grant_q);
    // R11: no grant while a locked pair is pending
    a_r11_no_grant_locked: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> !grant_q);
endmodule

// File: rtl/ebus_master.sv
module ebus_master #(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic          req_word,
    input  logic          req_lock,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          req_port8,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] bus_addr,
    output logic          bus_addr_oe,
    output logic          bus_strobe,
    output logic          bus_write,
    output logic          bus_lane_hi,
    output logic          bus_lane_lo,
    output logic [DW-1:0] bus_dout,
    output logic          bus_dout_oe,
    input  logic [DW-1:0] bus_din,
    input  logic          bus_ack,
    output logic          bus_rmw,
    input  logic          arb_req,
    output logic          arb_grant,
    input  logic          arb_gack
);
    import ebm_pkg::*;

    typedef struct packed {
        ebm_phase_e    ph;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          write;
        logic          word;
        logic          port8;
        logic          cur_lock;
        logic          lock;
        logic          rsp;
        logic [DW-1:0] rdata;
    } seq_t;

    seq_t s_d, s_q;

    logic          idle, busy, open, accept, active;
    logic          lane_hi, lane_lo;
    logic [DW-1:0] lane_dout, rdata_nx;
    logic [AW-1:0] beat_addr;

    assign idle   = (s_q.ph == PH_IDLE);
    assign active = !idle;
    assign busy   = arb_grant || arb_gack;
    assign open   = idle && !busy && (!arb_req || s_q.lock);
    assign accept = open && req_valid;

    ebm_arbiter u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .arb_req  (arb_req),
        .arb_gack (arb_gack),
        .idle     (idle),
        .lock     (s_q.lock),
        .grant    (arb_grant)
    );

    ebm_lanes #(.DW(DW)) u_lanes (
        .word     (s_q.word),
        .port8    (s_q.port8),
        .addr0    (s_q.addr[0]),
        .second   (s_q.ph == PH_BEAT1),
        .wdata    (s_q.wdata),
        .din      (bus_din),
        .rdata_q  (s_q.rdata),
        .lane_hi  (lane_hi),
        .lane_lo  (lane_lo),
        .dout     (lane_dout),
        .rdata_nx (rdata_nx)
    );

    always_comb begin
        if (!s_q.word)                 beat_addr = s_q.addr;
        else if (s_q.ph == PH_BEAT1)   beat_addr = {s_q.addr[AW-1:1], 1'b1};
        else                           beat_addr = {s_q.addr[AW-1:1], 1'b0};
    end

    always_comb begin
        s_d     = s_q;
        s_d.rsp = 1'b0;
        case (s_q.ph)
            PH_IDLE: begin
                if (accept) begin
                    s_d.ph       = PH_BEAT0;
                    s_d.addr     = req_addr;
                    s_d.wdata    = req_wdata;
                    s_d.write    = req_write;
                    s_d.word     = req_word;
                    s_d.port8    = req_port8;
                    s_d.cur_lock = req_lock;
                    s_d.lock     = s_q.lock || req_lock;
                    s_d.rdata    = '0;
                end
            end
            PH_BEAT0: begin
                if (bus_ack) begin
                    if (!s_q.write) s_d.rdata = rdata_nx;
                    if (s_q.word && s_q.port8) begin
                        s_d.ph = PH_BEAT1;
                    end else begin
                        s_d.ph   = PH_IDLE;
                        s_d.rsp  = 1'b1;
                        s_d.lock = s_q.cur_lock;
                    end
                end
            end
            PH_BEAT1: begin
                if (bus_ack) begin
                    if (!s_q.write) s_d.rdata = rdata_nx;
                    s_d.ph   = PH_IDLE;
                    s_d.rsp  = 1'b1;
                    s_d.lock = s_q.cur_lock;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_ready   = open;
    assign rsp_valid   = s_q.rsp;
    assign rsp_rdata   = s_q.rdata;
    assign bus_strobe  = active;
    assign bus_addr_oe = active;
    assign bus_addr    = active ? beat_addr : '0;
    assign bus_write   = active && s_q.write;
    assign bus_dout_oe = active && s_q.write;
    assign bus_dout    = bus_dout_oe ? lane_dout : '0;
    assign bus_lane_hi = active && lane_hi;
    assign bus_lane_lo = active && lane_lo;
    assign bus_rmw     = s_q.lock;

    // R7: an unacknowledged cycle holds its strobe and address
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bus_strobe && !bus_ack |=> bus_strobe && $stable(bus_addr) && $stable(bus_dout));
    // R8: completion is a single-cycle pulse
    a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R9: grant never overlaps a bus cycle
    a_r9_grant_idle: assert property (@(posedge clk) disable iff (!rst_n)
        arb_grant |-> !bus_strobe && !req_ready);
    // R9: silent while the other master owns the bus
    a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        arb_gack |-> !bus_addr_oe && !bus_dout_oe && !req_ready);
    // R12: data drive only inside a write cycle
    a_r12_dout: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dout_oe |-> bus_strobe && bus_write);
    // R3: the second byte cycle follows the first only for split words
    a_r3_split: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ph == PH_BEAT1 |-> s_q.word && s_q.port8 && bus_lane_hi && !bus_lane_lo);
endmodule

// File: tb/ebus_master_bench.sv
`timescale 1ns/1ps
module ebus_master_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0, req_lock = 1'b0, req_port8 = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic [23:0] bus_addr;
    logic        bus_addr_oe, bus_strobe, bus_write, bus_lane_hi, bus_lane_lo, bus_dout_oe, bus_rmw;
    logic [15:0] bus_dout, bus_din;
    logic        bus_ack = 1'b1, arb_req = 1'b0, arb_gack = 1'b0, arb_grant;
    logic        dev_p8 = 1'b0;
    int          nchk = 0, nfail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    ebus_master u_ebus_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_word(req_word), .req_lock(req_lock),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_port8(req_port8),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
        .bus_addr_oe(bus_addr_oe), .bus_strobe(bus_strobe), .bus_write(bus_write),
        .bus_lane_hi(bus_lane_hi), .bus_lane_lo(bus_lane_lo), .bus_dout(bus_dout),
        .bus_dout_oe(bus_dout_oe), .bus_din(bus_din), .bus_ack(bus_ack),
        .bus_rmw(bus_rmw), .arb_req(arb_req), .arb_grant(arb_grant), .arb_gack(arb_gack)
    );

    function automatic logic [7:0] mem_byte(input logic [23:0] a);
        return a[7:0] + 8'h11;
    endfunction

    assign bus_din = dev_p8 ? {mem_byte(bus_addr), 8'h00}
                            : {mem_byte({bus_addr[23:1], 1'b0}), mem_byte({bus_addr[23:1], 1'b1})};

    typedef struct packed {
        logic        wr, word, p8;
        logic [23:0] addr;
        logic [15:0] wdata;
        logic [1:0]  nb;
        logic [23:0] a0, a1;
        logic [1:0]  lanes;
        logic [15:0] d0, d1, rd;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{1'b0,1'b1,1'b0,24'h001230,16'h0000,2'd1,24'h001230,24'h000000,2'b11,16'h0000,16'h0000,16'h4142},
        '{1'b0,1'b1,1'b1,24'h001230,16'h0000,2'd2,24'h001230,24'h001231,2'b10,16'h0000,16'h0000,16'h4142},
        '{1'b0,1'b0,1'b0,24'h0000A5,16'h0000,2'd1,24'h0000A5,24'h000000,2'b01,16'h0000,16'h0000,16'h00B6},
        '{1'b0,1'b0,1'b0,24'h0000A4,16'h0000,2'd1,24'h0000A4,24'h000000,2'b10,16'h0000,16'h0000,16'h00B5},
        '{1'b0,1'b0,1'b1,24'h0000A5,16'h0000,2'd1,24'h0000A5,24'h000000,2'b10,16'h0000,16'h0000,16'h00B6},
        '{1'b1,1'b1,1'b0,24'hFFFFFE,16'hBEEF,2'd1,24'hFFFFFE,24'h000000,2'b11,16'hBEEF,16'h0000,16'h0000},
        '{1'b1,1'b1,1'b1,24'h800001,16'h1234,2'd2,24'h800000,24'h800001,2'b10,16'h1200,16'h3400,16'h0000},
        '{1'b1,1'b0,1'b0,24'h000011,16'h00C3,2'd1,24'h000011,24'h000000,2'b01,16'h00C3,16'h0000,16'h0000},
        '{1'b1,1'b0,1'b0,24'h000010,16'h77C3,2'd1,24'h000010,24'h000000,2'b10,16'hC300,16'h0000,16'h0000},
        '{1'b0,1'b1,1'b0,24'h000101,16'h0000,2'd1,24'h000100,24'h000000,2'b11,16'h0000,16'h0000,16'h1112}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // drive a request at a negedge; returns at the negedge showing the first beat
    task automatic issue(input logic wr, input logic word, input logic p8, input logic lock,
                         input logic [23:0] a, input logic [15:0] d);
        req_write = wr; req_word = word; req_port8 = p8; req_lock = lock;
        req_addr = a; req_wdata = d; req_valid = 1'b1; dev_p8 = p8;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input string tag);
        int nb = 0;
        issue(v.wr, v.word, v.p8, 1'b0, v.addr, v.wdata);
        while (bus_strobe && nb < 4) begin
            chk({tag, " lanes"}, {bus_lane_hi, bus_lane_lo}, v.lanes);
            chk({tag, " R12 dout_oe"}, bus_dout_oe, v.wr);
            chk({tag, " addr_oe"}, bus_addr_oe, 1'b1);
            chk({tag, " addr"}, bus_addr, (nb == 0) ? v.a0 : v.a1);
            if (v.wr) chk({tag, " dout"}, bus_dout, (nb == 0) ? v.d0 : v.d1);
            nb++;
            @(negedge clk);
        end
        chk({tag, " beats"}, nb, v.nb);
        chk({tag, " R8 rsp_valid"}, rsp_valid, 1'b1);
        if (!v.wr) chk({tag, " R8 rdata"}, rsp_rdata, v.rd);
        @(negedge clk);
        chk({tag, " R8 pulse"}, rsp_valid, 1'b0);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL R8 watchdog act=running exp=finished");
            finish_run();
        end
    end

    initial begin
        logic [23:0] held;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 strobe", bus_strobe, 1'b0);
        chk("R1 addr_oe", bus_addr_oe, 1'b0);
        chk("R1 dout_oe", bus_dout_oe, 1'b0);
        chk("R1 grant", arb_grant, 1'b0);
        chk("R1 rmw", bus_rmw, 1'b0);
        chk("R1 rsp", rsp_valid, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", req_ready, 1'b1);

        // R7: ack with no request has no effect
        bus_ack = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7 idle ack strobe", bus_strobe, 1'b0);
        chk("R7 idle ack rsp", rsp_valid, 1'b0);

        // table: R2 R3 R4 R5 R6 R12
        for (int i = 0; i < 10; i++) begin
            string tag;
            tag = VEC[i].word ? (VEC[i].p8 ? "R3" : "R2") : (VEC[i].p8 ? "R5" : "R4");
            if (i == 6 || i == 9) tag = {tag, " R6"};
            run_vec(VEC[i], $sformatf("%s v%0d", tag, i));
        end

        // R7: wait states hold the cycle
        bus_ack = 1'b0;
        issue(1'b0, 1'b1, 1'b0, 1'b0, 24'h000200, 16'h0);
        held = bus_addr;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R7 strobe held", bus_strobe, 1'b1);
            chk("R7 addr held", bus_addr, held);
        end
        chk("R7 no early rsp", rsp_valid, 1'b0);
        bus_ack = 1'b1;
        @(negedge clk);
        chk("R8 rsp after wait", rsp_valid, 1'b1);
        chk("R8 rdata after wait", rsp_rdata, 16'h1112);
        @(negedge clk);

        // R9 R10: plain arbitration
        arb_req = 1'b1;
        #0.1;
        chk("R9 ready low on req", req_ready, 1'b0);
        @(negedge clk);
        chk("R9 grant", arb_grant, 1'b1);
        req_valid = 1'b1; req_word = 1'b1; req_write = 1'b0; req_addr = 24'h000300;
        @(negedge clk);
        chk("R9 stalled strobe", bus_strobe, 1'b0);
        chk("R9 stalled addr_oe", bus_addr_oe, 1'b0);
        arb_gack = 1'b1; arb_req = 1'b0;
        @(negedge clk);
        chk("R10 grant drops", arb_grant, 1'b0);
        chk("R9 gack ready", req_ready, 1'b0);
        chk("R9 gack strobe", bus_strobe, 1'b0);
        @(negedge clk);
        chk("R9 gack addr_oe", bus_addr_oe, 1'b0);
        arb_gack = 1'b0;
        #0.1;
        chk("R10 ready returns", req_ready, 1'b1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 held request runs", bus_strobe, 1'b1);
        @(negedge clk);
        chk("R10 held request done", rsp_valid, 1'b1);
        @(negedge clk);

        // R9: request during a cycle waits for its end
        bus_ack = 1'b0;
        issue(1'b1, 1'b0, 1'b0, 1'b0, 24'h000040, 16'h0055);
        arb_req = 1'b1;
        repeat (2) begin
            @(negedge clk);
            chk("R9 no grant mid-cycle", arb_grant, 1'b0);
        end
        bus_ack = 1'b1;
        @(negedge clk);
        chk("R9 rsp before grant", rsp_valid, 1'b1);
        chk("R9 grant not yet", arb_grant, 1'b0);
        @(negedge clk);
        chk("R9 grant after cycle", arb_grant, 1'b1);
        arb_req = 1'b0;
        @(negedge clk);
        chk("R10 grant released", arb_grant, 1'b0);

        // R11: locked pair
        issue(1'b0, 1'b1, 1'b0, 1'b1, 24'h000030, 16'h0);
        chk("R11 rmw in first", bus_rmw, 1'b1);
        @(negedge clk);
        chk("R11 first done", rsp_valid, 1'b1);
        chk("R11 rmw between", bus_rmw, 1'b1);
        arb_req = 1'b1;
        @(negedge clk);
        chk("R11 no grant between", arb_grant, 1'b0);
        chk("R11 ready while locked", req_ready, 1'b1);
        issue(1'b1, 1'b1, 1'b0, 1'b0, 24'h000030, 16'hA5A5);
        chk("R11 rmw in second", bus_rmw, 1'b1);
        chk("R11 no grant in second", arb_grant, 1'b0);
        @(negedge clk);
        chk("R11 second done", rsp_valid, 1'b1);
        chk("R11 rmw cleared", bus_rmw, 1'b0);
        chk("R11 grant not yet", arb_grant, 1'b0);
        @(negedge clk);
        chk("R11 grant after pair", arb_grant, 1'b1);
        arb_req = 1'b0;
        @(negedge clk);
        chk("R10 grant released after pair", arb_grant, 1'b0);

        finish_run();
    end
endmodule